// File: doc/BRIEF.md
# I2C Master Start and Address Engine

This block is the master side of a two-wire serial bus controller, cut down to the opening of a transfer. Software programs a clock rate and an acknowledge mode. It loads an address byte, whose low bit is the direction. It then issues a single control write that raises the master, transmit, busy and pending bits together. The engine drives a start condition and clocks the byte out MSB first. In acknowledge mode it adds a ninth clock, on which it releases SDA and samples the slave's answer.

On the falling edge of the last clock, the engine raises a one-cycle interrupt and clears the pending bit. It then keeps SCL low until software writes the pending bit back to 1. If the slave acknowledged, the transmit bit takes the value the direction bit calls for: a read request turns the master into a receiver. Both bus lines are open drain. The block only ever pulls a line low, through `scl_oe` and `sda_oe`, and it reads the SDA level back on `sda_in`.

The register map has four byte locations. Offset 0 is setup: bit 3 selects acknowledge mode and bits 2:0 hold the rate code. Offset 1 is control and status. Offset 2 holds the address byte. Offset 3 is the own-address register: bits 7:1 hold an address and bit 0 selects the format. The block only stores the own-address register; nothing in this cut acts on it.

Top module: `i2c_addr_master`

## Requirements
- R1: A write to offset 1 starts a transfer when bits 7:4 (master, transmit, busy, pending) are all 1 and busy reads 0. The cycle after the write, SDA is pulled low while SCL stays released, and this lasts H system cycles. H is 2^(code+4), where the code is setup bits 2:0. SCL is then pulled low.
- R2: The address byte goes out MSB first, one bit per SCL clock. Each clock is H cycles low then H cycles high. SDA changes only while SCL is low.
- R3: With setup bit 3 at 1, a ninth clock follows the eighth. During the ninth clock SDA is released, and the slave's level is sampled at the end of its high phase.
- R4: With setup bit 3 at 1, irq is high for exactly one cycle, 19·H cycles after the start write. In that same cycle the pending bit (status bit 4) becomes 0.
- R5: While master is 1 and pending is 0, SCL stays pulled low. A control write with bit 4 at 1 releases SCL in the cycle after the write.
- R6: At the interrupt, transmit (status bit 6) becomes the inverse of the direction bit (address byte bit 0), but only if the sampled acknowledge was low. With no acknowledge, transmit keeps its value.
- R7: With setup bit 3 at 0, only eight clocks are produced and irq comes 17·H cycles after the start write. The acknowledge level and transmit are not updated.
- R8: After reset, control/status reads 0x10: master, transmit and busy are 0, pending is 1 and the acknowledge level is 0. Both line enables and irq are 0.
- R9: Status bit 0 holds the SDA level sampled on the ninth clock: 1 for no acknowledge.
- R10: A start request while busy is 1 has no effect on the lines or on the status. So does a control write that does not set all four of bits 7:4.
- R11: The own-address register at offset 3 reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| sda_in | input | 1 | Level seen on the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | One-cycle transfer-complete interrupt |

## Verification
Time is measured from the clock edge that takes the start write. SDA falls in the next cycle, and SCL first falls H cycles after that edge. The irq pulse is due 19·H cycles after it in acknowledge mode and 17·H without. A release write frees SCL one cycle after its own edge. The bench counts cycles from each write edge and compares the cycle in which irq appears with the due cycle it computes. It samples every output on the falling clock edge, so each registered change is already visible. Address bits are compared on each SCL rising edge against a queue filled by the driver, and status is read back only once the interrupt has been seen.

// File: rtl/i2cse_pkg.sv
package i2cse_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_DONE
  } eng_state_t;

  localparam logic [1:0] OFS_SETUP = 2'd0;
  localparam logic [1:0] OFS_CTRL  = 2'd1;
  localparam logic [1:0] OFS_DATA  = 2'd2;
  localparam logic [1:0] OFS_OWN   = 2'd3;

  localparam int CTRL_MST = 7;
  localparam int CTRL_TRX = 6;
  localparam int CTRL_BB  = 5;
  localparam int CTRL_PIN = 4;
  localparam int STAT_LRB = 0;

endpackage

// File: rtl/i2cse_regs.sv
module i2cse_regs
  import i2cse_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SCKW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      rd_addr,
  input  logic [DW-1:0]   stat_i,
  output logic [DW-1:0]   rd_data,
  output logic [DW-1:0]   data_q,
  output logic            ack_mode,
  output logic [SCKW-1:0] sck
);
  localparam int SETW = SCKW + 1;

  logic [SETW-1:0] setup_q, setup_d;
  logic [DW-1:0]   data_d;
  logic [DW-1:0]   own_q, own_d;

  always_comb begin
    setup_d = setup_q;
    data_d  = data_q;
    own_d   = own_q;
    if (wr_en) begin
      case (wr_addr)
        OFS_SETUP: setup_d = wr_data[SETW-1:0];
        OFS_DATA:  data_d  = wr_data;
        OFS_OWN:   own_d   = wr_data;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      data_q  <= '0;
      own_q   <= '0;
    end else begin
      setup_q <= setup_d;
      data_q  <= data_d;
      own_q   <= own_d;
    end
  end

  assign ack_mode = setup_q[SCKW];
  assign sck      = setup_q[SCKW-1:0];

  always_comb begin
    case (rd_addr)
      OFS_SETUP: rd_data = {{(DW-SETW){1'b0}}, setup_q};
      OFS_CTRL:  rd_data = stat_i;
      OFS_DATA:  rd_data = data_q;
      default:   rd_data = own_q;
    endcase
  end

endmodule

// File: rtl/i2cse_baud.sv
module i2cse_baud #(
  parameter int SCKW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [SCKW-1:0] sck,
  output logic            tick
);
  localparam int CNTW = (2 ** SCKW) + 3;

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CNTW:0]   span;
  logic [CNTW:0]   lim_full;

  always_comb begin
    span     = {{CNTW{1'b0}}, 1'b1} << (sck + 4);
    lim_full = span - {{CNTW{1'b0}}, 1'b1};
    tick     = run && (cnt_q == lim_full[CNTW-1:0]);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/i2cse_engine.sv
module i2cse_engine
  import i2cse_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] data_q,
  input  logic          ack_mode,
  input  logic          sda_in,
  input  logic          tick,
  output logic          run,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          irq,
  output logic          mst,
  output logic          trx,
  output logic          bb,
  output logic          pin,
  output logic          lrb
);
  localparam int BCW = $clog2(DW + 1);

  eng_state_t    state_q, state_d;
  logic [BCW-1:0] bitn_q, bitn_d, last_bit;
  logic [DW-1:0] shreg_q, shreg_d;
  logic          dir_q, dir_d, nine_q, nine_d;
  logic          mst_d, trx_d, bb_d, pin_d, lrb_d, irq_d;
  logic          ctrl_wr, start_req, pin_wr;

  assign ctrl_wr   = wr_en && (wr_addr == OFS_CTRL);
  assign start_req = ctrl_wr && (wr_data[CTRL_MST:CTRL_PIN] == 4'hF) && !bb;
  assign pin_wr    = ctrl_wr && wr_data[CTRL_PIN];
  assign last_bit  = nine_q ? BCW'(DW) : BCW'(DW - 1);

  always_comb begin
    state_d = state_q;
    bitn_d  = bitn_q;
    shreg_d = shreg_q;
    dir_d   = dir_q;
    nine_d  = nine_q;
    mst_d   = mst;
    trx_d   = trx;
    bb_d    = bb;
    pin_d   = pin;
    lrb_d   = lrb;
    irq_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          state_d = ST_START;
          shreg_d = data_q;
          dir_d   = data_q[0];
          nine_d  = ack_mode;
          bitn_d  = '0;
          mst_d   = 1'b1;
          trx_d   = 1'b1;
          bb_d    = 1'b1;
          pin_d   = 1'b1;
        end
      end
      ST_START: if (tick) state_d = ST_LOW;
      ST_LOW:   if (tick) state_d = ST_HIGH;
      ST_HIGH: begin
        if (tick) begin
          if (bitn_q == last_bit) begin
            state_d = ST_HOLD;
            pin_d   = 1'b0;
            irq_d   = 1'b1;
            if (nine_q) begin
              lrb_d = sda_in;
              if (!sda_in) trx_d = ~dir_q;
            end
          end else begin
            state_d = ST_LOW;
            bitn_d  = bitn_q + 1'b1;
            shreg_d = {shreg_q[DW-2:0], 1'b0};
          end
        end
      end
      ST_HOLD: begin
        if (pin_wr) begin
          pin_d   = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: ;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bitn_q  <= '0;
      shreg_q <= '0;
      dir_q   <= 1'b0;
      nine_q  <= 1'b0;
      mst     <= 1'b0;
      trx     <= 1'b0;
      bb      <= 1'b0;
      pin     <= 1'b1;
      lrb     <= 1'b0;
      irq     <= 1'b0;
    end else begin
      state_q <= state_d;
      bitn_q  <= bitn_d;
      shreg_q <= shreg_d;
      dir_q   <= dir_d;
      nine_q  <= nine_d;
      mst     <= mst_d;
      trx     <= trx_d;
      bb      <= bb_d;
      pin     <= pin_d;
      lrb     <= lrb_d;
      irq     <= irq_d;
    end
  end

  always_comb begin
    run    = (state_q == ST_START) || (state_q == ST_LOW) || (state_q == ST_HIGH);
    scl_oe = (state_q == ST_LOW) || (state_q == ST_HOLD);
    case (state_q)
      ST_START:       sda_oe = 1'b1;
      ST_LOW, ST_HIGH: sda_oe = (bitn_q < BCW'(DW)) ? ~shreg_q[DW-1] : 1'b0;
      default:        sda_oe = 1'b0;
    endcase
  end

endmodule

// File: rtl/i2c_addr_master.sv
module i2c_addr_master
  import i2cse_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SCKW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          irq
);
  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic [DW-1:0]   data_q, stat;
  logic            ack_mode, tick, run;
  logic [SCKW-1:0] sck;
  logic            mst, trx, bb, pin, lrb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    stat           = '0;
    stat[CTRL_MST] = mst;
    stat[CTRL_TRX] = trx;
    stat[CTRL_BB]  = bb;
    stat[CTRL_PIN] = pin;
    stat[STAT_LRB] = lrb;
  end

  i2cse_regs #(.DW(DW), .SCKW(SCKW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .stat_i(stat), .rd_data(rd_data),
    .data_q(data_q), .ack_mode(ack_mode), .sck(sck)
  );

  i2cse_baud #(.SCKW(SCKW)) u_baud (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .sck(sck), .tick(tick)
  );

  i2cse_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .data_q(data_q), .ack_mode(ack_mode), .sda_in(sda_in),
    .tick(tick), .run(run), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
    .mst(mst), .trx(trx), .bb(bb), .pin(pin), .lrb(lrb)
  );

endmodule

// File: rtl/i2cse_chk.sv
module i2cse_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic irq,
  input logic mst,
  input logic pin,
  input logic bb
);
  // R1
  start_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bb) |-> (sda_oe && !scl_oe));

  // R2
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && $past(bb)) |-> $stable(sda_oe));

  // R4
  irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !pin);

  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst && !pin) |-> scl_oe);

  // R10
  busy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bb) |-> bb);

endmodule

bind i2c_addr_master i2cse_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq(irq), .mst(mst), .pin(pin), .bb(bb)
);

// File: tb/tb_i2c_addr_master.sv
module tb_i2c_addr_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sda_in, scl_oe, sda_oe, irq;

  always #10 clk = ~clk;

  int  cyc = 0;
  int  checks = 0, errors = 0;
  int  irq_due = -1, irq_seen = 0, rise_cnt = 0;
  bit  xfer_active = 0, ack_en = 0, prev_scl = 0;
  string due_tag = "R4";
  bit  exp_q[$];
  logic slave_pull;

  assign slave_pull = xfer_active && ack_en && ((rise_cnt == 8 && scl_oe) || rise_cnt == 9);
  assign sda_in = !(sda_oe || slave_pull);

  i2c_addr_master dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sda_in(sda_in), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .irq(irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard of address bits, ninth-clock release, irq timing
  always @(negedge clk) begin
    if (xfer_active && prev_scl && !scl_oe) begin
      if (rise_cnt < 8) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected bit", rise_cnt, 0);
        else begin
          bit e;
          e = exp_q.pop_front();
          check((!sda_oe) == e, "R2 address bit", int'(!sda_oe), int'(e));
        end
      end else if (rise_cnt == 8)
        check(sda_oe == 1'b0, "R3 SDA released on ninth clock", sda_oe, 0);
      else
        check(0, "R7 extra SCL clock", rise_cnt + 1, 9);
      rise_cnt++;
    end
    if (irq) begin
      check(irq_due == cyc, due_tag, cyc, irq_due);
      irq_due = -1;
      xfer_active = 0;
      irq_seen++;
    end
    prev_scl = scl_oe;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    xfer_active = 0;
    irq_due = -1;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_xfer(input logic [7:0] data, input bit ackm, input int sck,
                          input bit slave_ack, input logic [7:0] exp_stat, input string tag);
    int h, t0, n, k;
    logic [7:0] s;
    h = 1 << (sck + 4);
    wr(2'd0, {4'b0, ackm, sck[2:0]});
    wr(2'd2, data);
    for (int i = 7; i >= 0; i--) exp_q.push_back(data[i]);
    ack_en = slave_ack;
    rise_cnt = 0;
    due_tag = ackm ? "R4 irq cycle (19H)" : "R7 irq cycle (17H)";
    n = irq_seen;
    xfer_active = 1;
    wr(2'd1, 8'hF0);
    t0 = cyc;
    irq_due = t0 + (ackm ? 19 : 17) * h;
    // R1: start condition shape
    check(sda_oe && !scl_oe, "R1 start SDA low SCL high", {sda_oe, scl_oe}, 2'b10);
    repeat (h - 1) @(negedge clk);
    check(sda_oe && !scl_oe, "R1 start held H cycles", {sda_oe, scl_oe}, 2'b10);
    @(negedge clk);
    check(scl_oe == 1'b1, "R1 SCL low after start", scl_oe, 1);
    k = 0;
    while (irq_seen == n && k < 25 * h) begin
      @(negedge clk);
      k++;
    end
    check(irq_seen == n + 1, "R4 irq raised", irq_seen - n, 1);
    check(exp_q.size() == 0, "R2 all bits sent", exp_q.size(), 0);
    rd(2'd1, s);
    check(s == exp_stat, tag, s, exp_stat);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int seen;
    do_reset();
    // R8 reset state
    rd(2'd1, s);
    check(s == 8'h10, "R8 status after reset", s, 8'h10);
    check(!scl_oe && !sda_oe && !irq, "R8 lines idle", {scl_oe, sda_oe, irq}, 0);
    // R11 own-address readback
    wr(2'd3, 8'hA5);
    rd(2'd3, s);
    check(s == 8'hA5, "R11 own address readback", s, 8'hA5);

    // read request, acknowledged: trx -> 0, lrb 0 (R6, R9)
    run_xfer(8'hA1, 1'b1, 0, 1'b1, 8'hA0, "R6 trx cleared on ack of read");
    // R5 SCL held while pending clear
    repeat (40) @(negedge clk);
    check(scl_oe == 1'b1, "R5 SCL held low", scl_oe, 1);
    wr(2'd1, 8'h10);
    check(scl_oe == 1'b0, "R5 SCL released after pending write", scl_oe, 0);
    rd(2'd1, s);
    check(s == 8'hB0, "R5 pending set after release", s, 8'hB0);
    // R10 start while busy ignored
    wr(2'd1, 8'hF0);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (scl_oe || sda_oe) seen++;
    end
    check(seen == 0, "R10 no bus activity when busy", seen, 0);
    rd(2'd1, s);
    check(s == 8'hB0, "R10 status unchanged when busy", s, 8'hB0);

    // read request, not acknowledged: trx stays, lrb 1 (R6, R9)
    do_reset();
    run_xfer(8'h5B, 1'b1, 0, 1'b0, 8'hE1, "R9 nack leaves trx, lrb set");

    // no acknowledge mode, slower rate (R7, R2)
    do_reset();
    run_xfer(8'h3C, 1'b0, 1, 1'b1, 8'hE0, "R7 eight clocks, no ack update");

    // write request acknowledged: trx stays 1 (R6)
    do_reset();
    run_xfer(8'h6A, 1'b1, 0, 1'b1, 8'hE0, "R6 trx kept for write direction");

    // R10 incomplete start request ignored
    do_reset();
    wr(2'd1, 8'h70);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (scl_oe || sda_oe || irq) seen++;
    end
    check(seen == 0, "R10 partial request no activity", seen, 0);
    rd(2'd1, s);
    check(s == 8'h10, "R10 partial request status", s, 8'h10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule